// File: doc/BRIEF.md
# Receive Frame Status Word Generator

This block sits beside a receive path and watches the byte stream of each incoming frame. It counts every byte, including the four trailing frame check bytes, and runs a CRC-32 over the whole frame. At the end of each frame it produces a 16-bit status word and a length. These two values are written back into the receive descriptor that held the frame.

The status word sorts the frame into error classes: a line error reported by the PHY, a trailing partial nibble, more bytes than the configured buffer holds, more bytes than the largest legal frame, fewer bytes than the smallest legal frame, and a bad CRC. A good-frame flag is set only when none of these apply. Only a good frame also carries the six address-match bits that the address filter supplies. The top bit of the word is the hardware ownership bit. It is always cleared, which returns the descriptor to the host.

Top module: `rx_frame_status`

## Requirements
- R1: After reset `wbValid` is 0 and `wbStatus` and `wbLength` are 0.
- R2: `wbValid` is high for exactly one cycle, in the cycle after the clock edge that accepts the end byte. `wbLength` counts every accepted byte of the frame, the 4 check bytes included.
- R3: Bit 15 of `wbStatus` (hardware ownership) is 0 in every write-back.
- R4: Bit 14 (good frame) is 1 exactly when bits 11 to 6 are all 0. Bits 13 and 12 are always 0.
- R5: Bit 7 (runt) is set when the length is below `MIN_FRAME` (64).
- R6: Bit 9 (buffer overflow) is set when the length exceeds `cfgBufSize`. Software normally programs 0x600.
- R7: Bit 8 (too long) is set when the length exceeds `MAX_FRAME` (default 1518).
- R8: Bits 5 to 0 copy `addrClass` (sampled with the end byte) only for a good frame, and are 0 otherwise.
- R9: Bit 6 (CRC error) is set when the CRC-32 over all bytes, check bytes included, does not leave the good residue. The CRC is reflected, with polynomial 0xEDB88320 and initial value all ones, and the sender appends the complemented CRC least significant byte first.
- R10: Bit 11 (PHY error) is set when `frmPhyErr` is high with any accepted byte of the frame.
- R11: Bit 10 (dribble) is set when `frmDribble` is high with the end byte.
- R12: A valid byte outside a frame has no effect and produces no write-back. A start during an open frame discards the open frame and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frmValid | input | 1 | A byte is present on `frmData` |
| frmStart | input | 1 | With `frmValid`: first byte of a frame |
| frmEnd | input | 1 | With `frmValid`: last byte of a frame |
| frmData | input | 8 | Received byte |
| frmPhyErr | input | 1 | Line error reported with this byte |
| frmDribble | input | 1 | With the end byte: a trailing partial nibble was seen |
| cfgBufSize | input | LEN_W | Receive buffer size in bytes |
| addrClass | input | 6 | Address-filter result bits, sampled with the end byte |
| wbValid | output | 1 | One-cycle write-back strobe |
| wbStatus | output | 16 | Descriptor status word |
| wbLength | output | LEN_W | Frame length in bytes, check bytes included |

## Verification
The bench builds the block with `MAX_FRAME` set to 200 and keeps `MIN_FRAME` at 64 and `LEN_W` at 16. This puts the too-long limit and its exact boundary within a few hundred cycles. The bench moves `cfgBufSize` at run time between 0x600 and 100, so a buffer overflow can be seen on its own, apart from a too-long frame. Lengths of 63, 64 and 200 bytes probe the exact runt and too-long limits. A single-byte frame shows that the runt and CRC flags can be set together.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;

  typedef struct packed {
    logic clear;   // first byte: restart accumulators
    logic accept;  // fold current byte in
    logic finish;  // last byte: emit write-back
  } rxStrobe_t;

  localparam int OWN_BIT  = 15;
  localparam int OK_BIT   = 14;
  localparam int PHY_BIT  = 11;
  localparam int DRIB_BIT = 10;
  localparam int BUF_BIT  = 9;
  localparam int LONG_BIT = 8;
  localparam int RUNT_BIT = 7;
  localparam int CRC_BIT  = 6;
  localparam int CLASS_W  = 6;

  localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY    = 32'hEDB8_8320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;

  function automatic logic [31:0] crcStep(input logic [31:0] crcIn, input logic [7:0] dataIn);
    logic [31:0] acc;
    acc = crcIn;
    for (int b = 0; b < 8; b++) begin
      if (acc[0] ^ dataIn[b]) acc = (acc >> 1) ^ CRC_POLY;
      else                    acc = acc >> 1;
    end
    return acc;
  endfunction

endpackage

// File: rtl/rx_stat_ctrl.sv
module rx_stat_ctrl
  import rx_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frmValid,
  input  logic       frmStart,
  input  logic       frmEnd,
  output rxStrobe_t  strobe
);

  typedef enum logic {ST_IDLE, ST_FRAME} ctrlState_t;

  ctrlState_t stateQ, stateNext;

  always_comb begin
    strobe = '0;
    if (frmValid && frmStart) begin
      strobe.clear  = 1'b1;
      strobe.accept = 1'b1;
      strobe.finish = frmEnd;
    end else if (frmValid && stateQ == ST_FRAME) begin
      strobe.accept = 1'b1;
      strobe.finish = frmEnd;
    end
  end

  always_comb begin
    stateNext = stateQ;
    if (strobe.finish)     stateNext = ST_IDLE;
    else if (strobe.clear) stateNext = ST_FRAME;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

  // R2
  finish_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |-> (frmValid && frmEnd));

  // R12
  stray_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && frmValid && !frmStart) |-> !strobe.accept);

endmodule

// File: rtl/rx_stat_dpath.sv
module rx_stat_dpath
  import rx_stat_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518
) (
  input  logic               clk,
  input  logic               rstN,
  input  rxStrobe_t          strobe,
  input  logic [7:0]         frmData,
  input  logic               frmPhyErr,
  input  logic               frmDribble,
  input  logic [LEN_W-1:0]   cfgBufSize,
  input  logic [CLASS_W-1:0] addrClass,
  output logic               wbValid,
  output logic [15:0]        wbStatus,
  output logic [LEN_W-1:0]   wbLength
);

  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_FRAME);
  localparam logic [LEN_W-1:0] LEN_SAT = {LEN_W{1'b1}};

  logic [LEN_W-1:0] lenQ, lenBase, lenNext;
  logic [31:0]      crcQ, crcBase, crcNext;
  logic             phyQ, phyBase, phyNext;
  logic [15:0]      statusNext;

  always_comb begin
    lenBase = strobe.clear ? '0       : lenQ;
    crcBase = strobe.clear ? CRC_INIT : crcQ;
    phyBase = strobe.clear ? 1'b0     : phyQ;
    lenNext = (lenBase == LEN_SAT) ? lenBase : lenBase + 1'b1;
    crcNext = crcStep(crcBase, frmData);
    phyNext = phyBase | frmPhyErr;
  end

  always_comb begin
    statusNext = '0;
    statusNext[PHY_BIT]  = phyNext;
    statusNext[DRIB_BIT] = frmDribble;
    statusNext[BUF_BIT]  = lenNext > cfgBufSize;
    statusNext[LONG_BIT] = lenNext > MAX_L;
    statusNext[RUNT_BIT] = lenNext < MIN_L;
    statusNext[CRC_BIT]  = crcNext != CRC_RESIDUE;
    statusNext[OK_BIT]   = ~|statusNext[PHY_BIT:CRC_BIT];
    if (statusNext[OK_BIT]) statusNext[CLASS_W-1:0] = addrClass;
    statusNext[OWN_BIT]  = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ <= '0;
      crcQ <= CRC_INIT;
      phyQ <= 1'b0;
    end else if (strobe.accept) begin
      lenQ <= lenNext;
      crcQ <= crcNext;
      phyQ <= phyNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbValid  <= 1'b0;
      wbStatus <= '0;
      wbLength <= '0;
    end else begin
      wbValid <= strobe.finish;
      if (strobe.finish) begin
        wbStatus <= statusNext;
        wbLength <= lenNext;
      end
    end
  end

  // R2
  wb_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> $past(strobe.finish));

  // R5
  runt_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbStatus[RUNT_BIT]) |-> (wbLength < MIN_L));

  // R7
  long_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbStatus[LONG_BIT]) |-> (wbLength > MAX_L));

  // R8
  class_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbStatus[OK_BIT]) |-> (wbStatus[CLASS_W-1:0] == '0));

endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
  import rx_stat_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frmValid,
  input  logic             frmStart,
  input  logic             frmEnd,
  input  logic [7:0]       frmData,
  input  logic             frmPhyErr,
  input  logic             frmDribble,
  input  logic [LEN_W-1:0] cfgBufSize,
  input  logic [5:0]       addrClass,
  output logic             wbValid,
  output logic [15:0]      wbStatus,
  output logic [LEN_W-1:0] wbLength
);

  rxStrobe_t strobe;

  rx_stat_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .frmValid (frmValid),
    .frmStart (frmStart),
    .frmEnd   (frmEnd),
    .strobe   (strobe)
  );

  rx_stat_dpath #(
    .LEN_W     (LEN_W),
    .MIN_FRAME (MIN_FRAME),
    .MAX_FRAME (MAX_FRAME)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .frmData    (frmData),
    .frmPhyErr  (frmPhyErr),
    .frmDribble (frmDribble),
    .cfgBufSize (cfgBufSize),
    .addrClass  (addrClass),
    .wbValid    (wbValid),
    .wbStatus   (wbStatus),
    .wbLength   (wbLength)
  );

endmodule

// File: tb/tb_rx_frame_status.sv
`timescale 1ns/1ps
module tb_rx_frame_status;

  localparam int LEN_W = 16;
  localparam int MAXF  = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frmValid = 0, frmStart = 0, frmEnd = 0, frmPhyErr = 0, frmDribble = 0;
  logic [7:0] frmData = '0;
  logic [LEN_W-1:0] cfgBufSize = 16'h0600;
  logic [5:0] addrClass = '0;
  logic wbValid;
  logic [15:0] wbStatus;
  logic [LEN_W-1:0] wbLength;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] frameBuf [0:255];
  int frameLen;

  always #2.5 clk = ~clk;

  rx_frame_status #(.LEN_W(LEN_W), .MIN_FRAME(64), .MAX_FRAME(MAXF)) dut (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmStart(frmStart), .frmEnd(frmEnd),
    .frmData(frmData), .frmPhyErr(frmPhyErr), .frmDribble(frmDribble),
    .cfgBufSize(cfgBufSize), .addrClass(addrClass),
    .wbValid(wbValid), .wbStatus(wbStatus), .wbLength(wbLength));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference CRC, one bit at a time, data shifted out LSB first
  function automatic logic [31:0] refCrc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    logic [7:0]  s = d;
    for (int k = 0; k < 8; k++) begin
      r = ((r ^ {31'b0, s[0]}) & 32'h1) != 0 ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
      s = s >> 1;
    end
    return r;
  endfunction

  task automatic buildFrame(input int payload, input int seed);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < payload; i++) begin
      frameBuf[i] = 8'((i * 7 + seed) & 8'hFF);
      c = refCrc(c, frameBuf[i]);
    end
    c = ~c;
    for (int j = 0; j < 4; j++) frameBuf[payload + j] = c[8*j +: 8];
    frameLen = payload + 4;
  endtask

  task automatic sendCheck(input string tag, input int phyAt, input bit drib,
                           input logic [5:0] cls, input logic [15:0] expStat);
    for (int i = 0; i < frameLen; i++) begin
      @(negedge clk);
      frmValid   = 1;
      frmStart   = (i == 0);
      frmEnd     = (i == frameLen - 1);
      frmData    = frameBuf[i];
      frmPhyErr  = (i == phyAt);
      frmDribble = drib && (i == frameLen - 1);
      addrClass  = (i == frameLen - 1) ? cls : 6'h00;
      if (i > 0) check({tag, " R2 no early strobe"}, 32'(wbValid), 0);
    end
    @(negedge clk);
    frmValid = 0; frmStart = 0; frmEnd = 0; frmPhyErr = 0; frmDribble = 0; addrClass = 0;
    check({tag, " R2 strobe"}, 32'(wbValid), 1);
    check({tag, " status"}, 32'(wbStatus), 32'(expStat));
    check({tag, " R2 length"}, 32'(wbLength), frameLen);
    check({tag, " R3 owner"}, 32'(wbStatus[15]), 0);
    @(negedge clk);
    check({tag, " R2 single cycle"}, 32'(wbValid), 0);
  endtask

  task automatic tReset();
    check("R1 wbValid", 32'(wbValid), 0);
    check("R1 wbStatus", 32'(wbStatus), 0);
    check("R1 wbLength", 32'(wbLength), 0);
  endtask

  task automatic tGood();
    buildFrame(60, 3);  sendCheck("R4 good 64", -1, 0, 6'h00, 16'h4000);
    buildFrame(100, 9); sendCheck("R8 good class", -1, 0, 6'h2D, 16'h402D);
    buildFrame(196, 1); sendCheck("R7 boundary 200", -1, 0, 6'h01, 16'h4001);
  endtask

  task automatic tRunt();
    buildFrame(59, 5);  sendCheck("R5 runt 63", -1, 0, 6'h3F, 16'h0080);
    frameBuf[0] = 8'h55; frameLen = 1;
    sendCheck("R5 R9 single byte", -1, 0, 6'h05, 16'h00C0);
  endtask

  task automatic tCrc();
    buildFrame(76, 11); frameBuf[20] = frameBuf[20] ^ 8'h10;
    sendCheck("R9 crc", -1, 0, 6'h07, 16'h0040);
  endtask

  task automatic tPhyDrib();
    buildFrame(80, 2); sendCheck("R10 phy", 10, 0, 6'h03, 16'h0800);
    buildFrame(80, 4); sendCheck("R11 dribble", -1, 1, 6'h03, 16'h0400);
  endtask

  task automatic tBufLong();
    cfgBufSize = 16'd100;
    buildFrame(146, 6); sendCheck("R6 buffer", -1, 0, 6'h01, 16'h0200);
    buildFrame(96, 6);  sendCheck("R6 buffer edge", -1, 0, 6'h01, 16'h4001);
    cfgBufSize = 16'h0600;
    buildFrame(216, 8); sendCheck("R7 too long", -1, 0, 6'h01, 16'h0100);
  endtask

  task automatic tIgnore();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      frmValid = 1; frmStart = 0; frmEnd = (i == 4); frmData = 8'hA5; frmPhyErr = 1;
    end
    @(negedge clk);
    frmValid = 0; frmEnd = 0; frmPhyErr = 0;
    check("R12 stray no strobe", 32'(wbValid), 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      frmValid = 1; frmStart = (i == 0); frmEnd = 0; frmData = 8'h3C; frmPhyErr = (i == 2);
    end
    @(negedge clk);
    frmValid = 0; frmStart = 0; frmPhyErr = 0;
    buildFrame(60, 12); sendCheck("R12 restart", -1, 0, 6'h11, 16'h4011);
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1;
    @(negedge clk);
    tGood();
    tRunt();
    tCrc();
    tPhyDrib();
    tBufLong();
    tIgnore();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule